// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the synchronized clock and data line samples of an I2C/SMBus port. It raises one sticky error flag when the bus has been held in an abnormal state for too long. A first timer has two modes. In the first it measures how long the clock line stays low without a break. In the second it measures how long both lines stay high together, which is the bus idle condition. A second timer adds up only the clock cycles during which this interface itself stretches the clock low. It starts over at every START, STOP or acknowledge strobe from the protocol engine.

Both timers take a 12-bit threshold from a small configuration port, and each has its own enable. Low-time measurement uses a step of 2048 cycles. Idle-time measurement uses a step of 4 cycles. A threshold, and for the first timer also the mode bit, is frozen while the timer that uses it is enabled. The protocol engine or a status path reads the error flag and pulses the clear input once the error has been handled.

Top module: `smb_tmo_top`

## Requirements
- R1: After reset the flag is 0 and both enables, both thresholds and the mode bit are 0, so holding SCL low for 3000 cycles raises no flag.
- R2: With timer A enabled and mode bit 0 (clock-low mode), the flag rises on the clock edge that completes (thrA+1) x 2048 consecutive cycles of SCL = 0, and not one cycle earlier.
- R3: With the mode bit 1 (idle mode), the flag rises after (thrA+1) x 4 consecutive cycles with SCL = 1 and SDA = 1; in this mode SCL held low raises no flag.
- R4: Timer A restarts from zero whenever its condition ends, and it fires at most once per continuous episode of the condition.
- R5: While the timer A enable is 0, timer A never raises the flag.
- R6: A write with cfg_sel_i = 0 always updates the timer A enable. It updates the timer A threshold and the mode bit only if the stored timer A enable was 0 before that write.
- R7: With timer B enabled, the flag rises when the number of cycles with stretch_i = 1 since the last restart reaches (thrB+1) x 2048. Cycles without stretch do not count and do not reset the total.
- R8: A START, STOP or acknowledge strobe resets the timer B total, and the cycle that carries the strobe is not counted.
- R9: A write with cfg_sel_i = 1 always updates the timer B enable. It updates the timer B threshold only if the stored timer B enable was 0 before that write. cfg_idle_i has no effect on such a write.
- R10: The flag stays set until tmo_clr_i is 1 for a cycle. A new expiry in the same cycle as the clear keeps the flag set.
- R11: Writing an enable to 0 resets that timer's count. After the enable is written to 1 again, counting starts from zero in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL line sample |
| sda_i | input | 1 | Synchronized SDA line sample |
| stretch_i | input | 1 | This interface is holding SCL low |
| start_i | input | 1 | START condition strobe |
| stop_i | input | 1 | STOP condition strobe |
| ack_i | input | 1 | Acknowledge bit strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects timer A, 1 selects timer B |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_idle_i | input | 1 | Mode bit for timer A (1 = idle mode) |
| cfg_thr_i | input | 12 | Threshold value to write |
| tmo_clr_i | input | 1 | One-cycle flag clear |
| tmo_o | output | 1 | Sticky timeout error flag |

## Verification
The checker tests on every cycle that the flag holds unless a clear arrives, and that it only rises after a timer hit. It also checks that a hit matches the line state of the selected mode, that no hit happens while a timer is disabled or while a timer B restart strobe is present, and that thresholds and the mode bit stay fixed while their enable is set. Only the bench scenarios can show the exact expiry cycle for each threshold and step size. The same holds for the restart of timer A when its condition breaks, for accumulation of timer B across gaps in stretching, for reset of the total by each strobe kind, for a clear that lands on the expiry cycle, and for counting that starts afresh after an enable is turned off and on again.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  typedef enum logic {
    SEL_TMR_A = 1'b0,
    SEL_TMR_B = 1'b1
  } tmr_sel_e;

  function automatic int unsigned step_last(input int unsigned log2_step);
    return (32'd1 << log2_step) - 32'd1;
  endfunction

endpackage

// File: rtl/smb_tmo_cfg.sv
module smb_tmo_cfg
  import smb_tmo_pkg::*;
#(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic             en_in,
  input  logic             idle_in,
  input  logic [THR_W-1:0] thr_in,
  output logic             en_a,
  output logic             idle_a,
  output logic [THR_W-1:0] thr_a,
  output logic             en_b,
  output logic [THR_W-1:0] thr_b
);

  logic             en_a_d, idle_a_d, en_b_d;
  logic [THR_W-1:0] thr_a_d, thr_b_d;
  logic             wr_a, wr_b;

  assign wr_a = wr && (sel == SEL_TMR_A);
  assign wr_b = wr && (sel == SEL_TMR_B);

  always_comb begin
    en_a_d   = en_a;
    idle_a_d = idle_a;
    thr_a_d  = thr_a;
    en_b_d   = en_b;
    thr_b_d  = thr_b;
    if (wr_a) begin
      en_a_d = en_in;
      if (!en_a) begin
        idle_a_d = idle_in;
        thr_a_d  = thr_in;
      end
    end
    if (wr_b) begin
      en_b_d = en_in;
      if (!en_b) begin
        thr_b_d = thr_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a   <= 1'b0;
      idle_a <= 1'b0;
      thr_a  <= '0;
      en_b   <= 1'b0;
      thr_b  <= '0;
    end else if (wr) begin
      en_a   <= en_a_d;
      idle_a <= idle_a_d;
      thr_a  <= thr_a_d;
      en_b   <= en_b_d;
      thr_b  <= thr_b_d;
    end
  end

endmodule

// File: rtl/smb_tmo_cnt.sv
module smb_tmo_cnt #(
  parameter int PRE_W = 11,
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  input  logic [PRE_W-1:0] pre_last,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [THR_W-1:0] unit_q, unit_d;
  logic             done_q, done_d;
  logic             cnt_ce;

  assign cnt_ce = restart || (adv && !done_q);

  always_comb begin
    pre_d  = pre_q;
    unit_d = unit_q;
    done_d = done_q;
    hit    = 1'b0;
    if (restart) begin
      pre_d  = '0;
      unit_d = '0;
      done_d = 1'b0;
    end else if (adv && !done_q) begin
      if (pre_q == pre_last) begin
        pre_d = '0;
        if (unit_q == thr) begin
          hit    = 1'b1;
          done_d = 1'b1;
          unit_d = '0;
        end else begin
          unit_d = unit_q + {{(THR_W-1){1'b0}}, 1'b1};
        end
      end else begin
        pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else if (cnt_ce) begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/smb_tmo_top.sv
module smb_tmo_top
  import smb_tmo_pkg::*;
#(
  parameter int THR_W    = 12,
  parameter int LOW_LOG  = 11,
  parameter int IDLE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             stretch_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ack_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic             cfg_en_i,
  input  logic             cfg_idle_i,
  input  logic [THR_W-1:0] cfg_thr_i,
  input  logic             tmo_clr_i,
  output logic             tmo_o
);

  localparam int PRE_W = (LOW_LOG > IDLE_LOG) ? LOW_LOG : IDLE_LOG;
  localparam logic [PRE_W-1:0] LOW_LAST  = PRE_W'(step_last(LOW_LOG));
  localparam logic [PRE_W-1:0] IDLE_LAST = PRE_W'(step_last(IDLE_LOG));

  logic             en_a, idle_a, en_b;
  logic [THR_W-1:0] thr_a, thr_b;
  logic             cond_a, restart_a, restart_b;
  logic [PRE_W-1:0] last_a;
  logic             hit_a, hit_b;
  logic             tmo_q, tmo_d;

  smb_tmo_cfg #(.THR_W(THR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr_i),
    .sel     (cfg_sel_i),
    .en_in   (cfg_en_i),
    .idle_in (cfg_idle_i),
    .thr_in  (cfg_thr_i),
    .en_a    (en_a),
    .idle_a  (idle_a),
    .thr_a   (thr_a),
    .en_b    (en_b),
    .thr_b   (thr_b)
  );

  // Timer A watches either clock-low or both-lines-high
  assign cond_a    = idle_a ? (scl_i && sda_i) : !scl_i;
  assign last_a    = idle_a ? IDLE_LAST : LOW_LAST;
  assign restart_a = !en_a || !cond_a;

  smb_tmo_cnt #(.PRE_W(PRE_W), .THR_W(THR_W)) u_tmr_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_a),
    .adv      (cond_a),
    .pre_last (last_a),
    .thr      (thr_a),
    .hit      (hit_a)
  );

  // Timer B accumulates local stretch between protocol strobes
  assign restart_b = !en_b || start_i || stop_i || ack_i;

  smb_tmo_cnt #(.PRE_W(PRE_W), .THR_W(THR_W)) u_tmr_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_b),
    .adv      (stretch_i),
    .pre_last (LOW_LAST),
    .thr      (thr_b),
    .hit      (hit_b)
  );

  always_comb begin
    tmo_d = tmo_q;
    if (tmo_clr_i) tmo_d = 1'b0;
    if (hit_a || hit_b) tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= tmo_d;
  end

  assign tmo_o = tmo_q;

endmodule

// File: rtl/smb_tmo_chk.sv
module smb_tmo_chk #(
  parameter int THR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl,
  input logic             sda,
  input logic             start,
  input logic             stop,
  input logic             ack,
  input logic             clr,
  input logic             tmo,
  input logic             en_a,
  input logic             idle_a,
  input logic [THR_W-1:0] thr_a,
  input logic             en_b,
  input logic [THR_W-1:0] thr_b,
  input logic             hit_a,
  input logic             hit_b
);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !clr) |=> tmo);

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(hit_a || hit_b));

  // R2
  hit_a_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |-> (idle_a ? (scl && sda) : !scl));

  // R5
  a_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |-> !hit_a);

  // R7
  b_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |-> !hit_b);

  // R8
  b_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop || ack) |-> !hit_b);

  // R6
  a_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_a) |-> ($stable(thr_a) && $stable(idle_a)));

  // R9
  b_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_b) |-> $stable(thr_b));

endmodule

bind smb_tmo_top smb_tmo_chk #(.THR_W(THR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl    (scl_i),
  .sda    (sda_i),
  .start  (start_i),
  .stop   (stop_i),
  .ack    (ack_i),
  .clr    (tmo_clr_i),
  .tmo    (tmo_o),
  .en_a   (en_a),
  .idle_a (idle_a),
  .thr_a  (thr_a),
  .en_b   (en_b),
  .thr_b  (thr_b),
  .hit_a  (hit_a),
  .hit_b  (hit_b)
);

// File: tb/smb_tmo_top_test.sv
`timescale 1ns/1ps
module smb_tmo_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_i = 1'b1, sda_i = 1'b1, stretch_i = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, ack_i = 1'b0;
  logic        cfg_wr_i = 1'b0, cfg_sel_i = 1'b0, cfg_en_i = 1'b0, cfg_idle_i = 1'b0;
  logic [11:0] cfg_thr_i = '0;
  logic        tmo_clr_i = 1'b0;
  logic        tmo_o;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  smb_tmo_top uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .stretch_i(stretch_i), .start_i(start_i), .stop_i(stop_i), .ack_i(ack_i),
    .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i), .cfg_en_i(cfg_en_i),
    .cfg_idle_i(cfg_idle_i), .cfg_thr_i(cfg_thr_i), .tmo_clr_i(tmo_clr_i),
    .tmo_o(tmo_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (tmo_o !== exp) begin
      errors++;
      $display("FAIL %s tmo_o=%b expected=%b at %0t", req, tmo_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    scl_i = 1'b1; sda_i = 1'b1; stretch_i = 1'b0;
    start_i = 1'b0; stop_i = 1'b0; ack_i = 1'b0; tmo_clr_i = 1'b0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic cfg_write(input logic sel, input logic en, input logic idle,
                           input logic [11:0] thr);
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_en_i = en; cfg_idle_i = idle; cfg_thr_i = thr;
    tick(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic clear_flag();
    tmo_clr_i = 1'b1;
    tick(1);
    tmo_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1 flag after reset");
    scl_i = 1'b0;
    tick(3000);
    check(1'b0, "R1 zero config stays quiet");
  endtask

  task automatic t_scl_low();
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0, 12'd1);
    scl_i = 1'b0;
    tick(4095);
    check(1'b0, "R2 one cycle before expiry");
    tick(1);
    check(1'b1, "R2 expiry at (1+1)*2048");
    tick(10);
    check(1'b1, "R10 flag sticky");
    clear_flag();
    check(1'b0, "R10 clear pulse");
    tick(5000);
    check(1'b0, "R4 once per episode");
    scl_i = 1'b1;
    tick(1);
    scl_i = 1'b0;
    tick(4096);
    check(1'b1, "R4 new episode fires");
  endtask

  task automatic t_restart();
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0, 12'd0);
    scl_i = 1'b0;
    tick(2000);
    scl_i = 1'b1;
    tick(1);
    scl_i = 1'b0;
    tick(2047);
    check(1'b0, "R4 count restarted after SCL high");
    tick(1);
    check(1'b1, "R4 fires after full fresh window");
  endtask

  task automatic t_idle();
    do_reset();
    sda_i = 1'b0;
    cfg_write(1'b0, 1'b1, 1'b1, 12'd3);
    sda_i = 1'b1;
    tick(15);
    check(1'b0, "R3 idle one before expiry");
    tick(1);
    check(1'b1, "R3 idle expiry at (3+1)*4");
    clear_flag();
    scl_i = 1'b0;
    tick(3000);
    check(1'b0, "R3 SCL low ignored in idle mode");
  endtask

  task automatic t_lock_a();
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0, 12'd0);
    cfg_write(1'b0, 1'b1, 1'b1, 12'd1);
    scl_i = 1'b0;
    tick(2047);
    check(1'b0, "R6 locked threshold before expiry");
    tick(1);
    check(1'b1, "R6 locked threshold and mode kept");
  endtask

  task automatic t_disable();
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0, 12'd0);
    scl_i = 1'b0;
    tick(2000);
    cfg_write(1'b0, 1'b0, 1'b0, 12'd0);
    tick(3000);
    check(1'b0, "R5 disabled timer quiet");
    cfg_write(1'b0, 1'b1, 1'b0, 12'd0);
    tick(2047);
    check(1'b0, "R11 count reset by disable");
    tick(1);
    check(1'b1, "R11 fires after re-enable window");
  endtask

  task automatic t_ext();
    do_reset();
    cfg_write(1'b1, 1'b1, 1'b0, 12'd0);
    stretch_i = 1'b1;
    tick(1000);
    stretch_i = 1'b0;
    tick(500);
    stretch_i = 1'b1;
    tick(1047);
    check(1'b0, "R7 cumulative one before expiry");
    tick(1);
    check(1'b1, "R7 cumulative stretch expiry");
    stretch_i = 1'b0;
  endtask

  task automatic t_ext_strobes();
    for (int k = 0; k < 3; k++) begin
      do_reset();
      cfg_write(1'b1, 1'b1, 1'b0, 12'd0);
      stretch_i = 1'b1;
      tick(2000);
      start_i = (k == 0);
      stop_i  = (k == 1);
      ack_i   = (k == 2);
      tick(1);
      start_i = 1'b0; stop_i = 1'b0; ack_i = 1'b0;
      tick(2047);
      check(1'b0, "R8 strobe reset accumulation");
      tick(1);
      check(1'b1, "R8 fires after fresh window");
      stretch_i = 1'b0;
    end
  endtask

  task automatic t_lock_b();
    do_reset();
    cfg_write(1'b1, 1'b1, 1'b0, 12'd0);
    cfg_write(1'b1, 1'b1, 1'b1, 12'd5);
    stretch_i = 1'b1;
    tick(2048);
    check(1'b1, "R9 locked timer B threshold");
    stretch_i = 1'b0;
    clear_flag();
    scl_i = 1'b1; sda_i = 1'b1;
    tick(100);
    check(1'b0, "R9 idle bit ignored on timer B write");
  endtask

  task automatic t_clr_prio();
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0, 12'd0);
    scl_i = 1'b0;
    tick(2047);
    tmo_clr_i = 1'b1;
    tick(1);
    tmo_clr_i = 1'b0;
    check(1'b1, "R10 expiry wins over clear");
    tick(1);
    check(1'b1, "R10 still set");
    clear_flag();
    check(1'b0, "R10 cleared afterwards");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_scl_low();
    t_restart();
    t_idle();
    t_lock_a();
    t_disable();
    t_ext();
    t_ext_strobes();
    t_lock_b();
    t_clr_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule